// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers level-sensitive interrupt sources into groups of eight and drives one request line per group toward a parent interrupt controller. Each source has its own enable bit. A group's line is high for as long as at least one of its enabled sources is high. Nothing is latched, so the line drops as soon as the sources drop or their enables are removed.

Software reaches the block through a simple 32-bit bus with word addresses and a combinational read path. Four neighbouring groups share one register bank. The bank holds four registers:
- a write-one-to-set enable register;
- a write-one-to-clear enable register;
- an unused slot;
- a read-only status register.

Group n uses byte lane n mod 4 of its bank, and banks follow one another every four words. The group count is a parameter. If it is not a multiple of four, the last bank has lanes with no group behind them, and those lanes behave as if empty.

The block has no sequencing. It consists of enable flip-flops, masking gates and a read multiplexer, so it has no states and no transitions.

Top module: `grouped_irq_combiner`

## Requirements
- R1: The output line of group g is high exactly when some source in irq_src[8g+7:8g] is high and its enable bit is set. The line is not latched and falls in the same cycle as the last such source.
- R2: A write to word offset 0 of a bank (byte offset 0x0) sets every enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R3: A write to word offset 1 of a bank (byte offset 0x4) clears every enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R4: Reading word offset 3 (byte offset 0xC) returns the source level ANDed with the enable bit, for every source of the bank's four groups.
- R5: Group n lives in bank n/4 at word address 4*(n/4) (byte stride 0x10). It uses bits 8*(n mod 4) through 8*(n mod 4)+7 of every register in that bank.
- R6: After reset, all enable bits are 0 and all output lines are low.
- R7: Reading word offset 0 or word offset 1 returns the current enable mask of the bank.
- R8: Writes to the status offset, to the unused word offset 2, or to addresses beyond the last bank change no enable bit. Reads of offset 2 and of addresses beyond the last bank return 0.
- R9: Byte lanes of groups that are not implemented read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address: upper bits pick the bank, lower two pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_src | input | NUM_GROUPS*8 | Level-sensitive sources, group g at bits 8g+7..8g |
| irq_out | output | NUM_GROUPS | One request line per group |

## Verification
A wrong enable bit shows at the ports as soon as the write that caused it has been clocked in. It appears both in the read-back of offsets 0 and 1 and on irq_out as soon as the matching source is driven. A lane or bank decode error makes a write land in the wrong group's byte. The next read of either bank, or a source raised in the affected group, then shows the error within one cycle. Because the output is unlatched, a line that stays high after its sources fall is visible in the cycle of that fall.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_PER_GROUP   = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int WORD_W          = SRC_PER_GROUP * GROUPS_PER_BANK;

    typedef enum logic [1:0] {
        REG_EN_SET = 2'd0,
        REG_EN_CLR = 2'd1,
        REG_RSVD   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_we,
    input  logic                     clr_we,
    input  logic [SRC_PER_GROUP-1:0] wdata,
    input  logic [SRC_PER_GROUP-1:0] src,
    output logic [SRC_PER_GROUP-1:0] en_q,
    output logic [SRC_PER_GROUP-1:0] status,
    output logic                     irq
);
    logic [SRC_PER_GROUP-1:0] set_mask;
    logic [SRC_PER_GROUP-1:0] clr_mask;

    always_comb begin
        set_mask = set_we ? wdata : '0;
        clr_mask = clr_we ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

    always_comb begin
        status = src & en_q;
        irq    = |status;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(wdata)) == $past(wdata))); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en_q & $past(wdata)) == '0)); // R3
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_q)); // R8
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int LANES_USED = GROUPS_PER_BANK
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_set,
    input  logic                                wr_clr,
    input  logic [WORD_W-1:0]                   wdata,
    input  logic [LANES_USED*SRC_PER_GROUP-1:0] src,
    output logic [WORD_W-1:0]                   en_word,
    output logic [WORD_W-1:0]                   stat_word,
    output logic [LANES_USED-1:0]               irq
);
    for (genvar l = 0; l < GROUPS_PER_BANK; l++) begin : g_lane
        if (l < LANES_USED) begin : g_used
            irqc_group u_grp (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_we (wr_set),
                .clr_we (wr_clr),
                .wdata  (wdata[l*SRC_PER_GROUP +: SRC_PER_GROUP]),
                .src    (src[l*SRC_PER_GROUP +: SRC_PER_GROUP]),
                .en_q   (en_word[l*SRC_PER_GROUP +: SRC_PER_GROUP]),
                .status (stat_word[l*SRC_PER_GROUP +: SRC_PER_GROUP]),
                .irq    (irq[l])
            );
        end else begin : g_empty
            assign en_word[l*SRC_PER_GROUP +: SRC_PER_GROUP]   = '0;
            assign stat_word[l*SRC_PER_GROUP +: SRC_PER_GROUP] = '0;
        end
    end
endmodule

// File: rtl/grouped_irq_combiner.sv
module grouped_irq_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 6,
    parameter int ADDR_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [WORD_W-1:0]               bus_wdata,
    output logic [WORD_W-1:0]               bus_rdata,
    input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] irq_src,
    output logic [NUM_GROUPS-1:0]           irq_out
);
    localparam int NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int BANK_W    = ADDR_W - 2;

    logic [BANK_W-1:0] bank_sel;
    reg_sel_e          reg_sel;
    logic [WORD_W-1:0] en_words   [NUM_BANKS];
    logic [WORD_W-1:0] stat_words [NUM_BANKS];

    assign bank_sel = bus_addr[ADDR_W-1:2];
    assign reg_sel  = reg_sel_e'(bus_addr[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int USED = (NUM_GROUPS - b*GROUPS_PER_BANK) < GROUPS_PER_BANK ?
                              (NUM_GROUPS - b*GROUPS_PER_BANK) : GROUPS_PER_BANK;
        logic hit;
        assign hit = bus_wr && (bank_sel == BANK_W'(b));

        irqc_bank #(.LANES_USED(USED)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_set    (hit && (reg_sel == REG_EN_SET)),
            .wr_clr    (hit && (reg_sel == REG_EN_CLR)),
            .wdata     (bus_wdata),
            .src       (irq_src[b*WORD_W +: USED*SRC_PER_GROUP]),
            .en_word   (en_words[b]),
            .stat_word (stat_words[b]),
            .irq       (irq_out[b*GROUPS_PER_BANK +: USED])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BANK_W'(b)) begin
                unique case (reg_sel)
                    REG_EN_SET, REG_EN_CLR: bus_rdata = en_words[b];
                    REG_STATUS:             bus_rdata = stat_words[b];
                    REG_RSVD:               bus_rdata = '0;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        AST_OUT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[g] |-> (|irq_src[g*SRC_PER_GROUP +: SRC_PER_GROUP])); // R1
    end
    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_out == '0)); // R6
endmodule

// File: tb/grouped_irq_combiner_tb_top.sv
module grouped_irq_combiner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [47:0] src;
        logic [5:0]  irq;
    } step_t;

    // wr=1: data is write data; wr=0: data is expected read data
    localparam step_t STEPS [16] = '{
        '{1'b0, 8'd0, 32'h0000_0000, 48'h0,              6'b000000}, // R6
        '{1'b1, 8'd0, 32'h0000_00A5, 48'h0,              6'b000000}, // R2
        '{1'b0, 8'd0, 32'h0000_00A5, 48'h0,              6'b000000}, // R7
        '{1'b0, 8'd3, 32'h0000_0001, 48'h1,              6'b000001}, // R4 R1
        '{1'b0, 8'd3, 32'h0000_0000, 48'h2,              6'b000000}, // R1 no latch
        '{1'b1, 8'd1, 32'h0000_0001, 48'h1,              6'b000000}, // R3
        '{1'b0, 8'd0, 32'h0000_00A4, 48'h4,              6'b000001}, // R3 R7
        '{1'b1, 8'd0, 32'h8000_0000, 48'h8000_0004,      6'b001001}, // R5
        '{1'b0, 8'd1, 32'h8000_00A4, 48'h8000_0004,      6'b001001}, // R7
        '{1'b0, 8'd3, 32'h8000_0004, 48'h8000_0004,      6'b001001}, // R4
        '{1'b1, 8'd4, 32'hFFFF_0101, 48'h0100_0000_0000, 6'b100000}, // R5 R9
        '{1'b0, 8'd4, 32'h0000_0101, 48'h0,              6'b000000}, // R9
        '{1'b1, 8'd6, 32'hFFFF_FFFF, 48'h0,              6'b000000}, // R8
        '{1'b1, 8'd3, 32'hFFFF_FFFF, 48'h0,              6'b000000}, // R8
        '{1'b1, 8'd8, 32'hFFFF_FFFF, 48'h0,              6'b000000}, // R8
        '{1'b0, 8'd7, 32'h0000_0101, 48'hFFFF_FFFF_FFFF, 6'b111001}  // R4 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] irq_src = '0;
    logic [5:0]  irq_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grouped_irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R6 irq after reset", {26'd0, irq_out}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            irq_src = STEPS[i].src;
            bus_addr = STEPS[i].addr;
            if (STEPS[i].wr) begin
                bus_wdata = STEPS[i].data;
                bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
                #1;
            end else begin
                #1 check($sformatf("R2-step%0d rdata", i), bus_rdata, STEPS[i].data);
            end
            check($sformatf("R1 step%0d irq", i), {26'd0, irq_out}, {26'd0, STEPS[i].irq});
        end
        // directed: all enable words after the table
        rd(8'd0, 32'h8000_00A4, "R8 status write ignored");
        rd(8'd2, 32'h0, "R8 reserved reads zero");
        rd(8'd8, 32'h0, "R8 beyond last bank");
        rd(8'd5, 32'h0000_0101, "R9 unused lanes");
        // clear all in bank1, source held high, output must fall
        irq_src = 48'hFFFF_FFFF_FFFF;
        wr(8'd5, 32'hFFFF_FFFF);
        #1 check("R3 bank1 cleared irq", {26'd0, irq_out}, 32'h0000_0009);
        // mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R6 irq in reset", {26'd0, irq_out}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'd0, 32'h0, "R6 enables zero after reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule